// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel Sequencer

This block is the control state machine of one memory-to-memory DMA channel. It holds two buffer byte counters and tracks how full a 16-byte staging bay is. It sequences read beats that fill the bay and write beats that empty it. A transfer is launched by a software start pulse or by a peripheral request line, depending on a 2-bit trigger-mode field. The peripheral width field sets how many bytes each beat moves.

When the active buffer runs dry and the other buffer still holds bytes, the sequencer changes buffer without software help. It can flag that change with a one-cycle interrupt pulse. A wait input parks the machine while a byte-count update completes. On release, the machine resumes reading or writing, depending on whether the bay held data when the wait began. The memory side is a simple request/acknowledge pair for reads and another for writes.

Top module: `m2m_dma_fsm`

## Requirements
- R1: A transfer starts only from IDLE or STALL. With `xfer_mode`=00 the trigger is `sw_start` and `dreq` is ignored. With 01 or 10 the trigger is `dreq` and `sw_start` is ignored. Mode 11 never starts.
- R2: When a trigger arrives and neither buffer count is valid, `state` becomes STALL (code 1) and neither `rd_req` nor `wr_req` is raised. State codes: IDLE 0, STALL 1, MEM_RD 2, MEM_WR 3, BWC_WAIT 4.
- R3: In mode 00, any non-zero count is valid.
- R4: In modes 01/10, a count is valid only when it is at least the beat size. `per_width` 00 means byte (1), 01 means half-word (2), and 10 or 11 means word (4).
- R5: In MEM_RD, every acknowledged read beat moves min(beat size, remaining count) bytes, shown on `xfer_bytes`. Reading ends when the count reaches zero or when the bay cannot take another full beat within its 16 bytes. `rd_req` and `wr_req` are never both high.
- R6: In MEM_WR, every acknowledged write beat moves min(beat size, bay level) bytes. Once the bay is empty and the count is still non-zero, reading resumes: at once in mode 00, or only when `dreq` is high in modes 01/10. Until then the machine stays in MEM_WR with both requests low.
- R7: When the bay is empty, the active count is zero and the other count is non-zero, `cur_buf` toggles and reading restarts. `nfb_irq` pulses for one cycle only if `nfb_irq_en` is set.
- R8: `bwc_wait` moves MEM_RD (no beat acknowledged) or MEM_WR (bay not empty, no beat acknowledged) into BWC_WAIT. When `bwc_wait` drops, the machine goes to MEM_RD if the bay was empty on entry, and to MEM_WR otherwise.
- R9: When the bay is empty and both counts are zero, the machine returns to IDLE and pulses `done` for one cycle.
- R10: After reset, `state` is IDLE, `cur_buf` is 0, both counts are 0, and every request and pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start trigger |
| xfer_mode | input | 2 | Trigger mode select |
| per_width | input | 2 | Peripheral width, sets beat size |
| dreq | input | 1 | Peripheral/external request |
| bwc_wait | input | 1 | Byte-count update wait |
| nfb_irq_en | input | 1 | Enable for buffer-switch pulse |
| bcnt_ld | input | 1 | Load strobe for a byte counter |
| bcnt_ld_sel | input | 1 | Counter selected by the load |
| bcnt_ld_val | input | 16 | Value loaded |
| rd_req | output | 1 | Memory read request |
| rd_ack | input | 1 | Read beat accepted |
| wr_req | output | 1 | Memory write request |
| wr_ack | input | 1 | Write beat accepted |
| xfer_bytes | output | 3 | Bytes moved by the current accepted beat |
| nfb_irq | output | 1 | Buffer-switch pulse |
| done | output | 1 | Transfer finished pulse |
| state | output | 3 | Current state code |
| cur_buf | output | 1 | Active buffer |

## Verification
A wrong bay level or count shows up within one beat: a short or long `xfer_bytes` value, or an extra or missing read or write beat, is caught when the next beat event is compared against the expected sequence. A wrong buffer or completion decision shows up one cycle after the bay drains, as a misplaced `nfb_irq` or `done` pulse or a `state` code other than the expected one. Stall, trigger-ignore and wait-exit mistakes are visible on `state` on the very next clock edge.

// File: rtl/m2m_dma_pkg.sv
package m2m_dma_pkg;
  parameter int BCNT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STALL = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_BWC   = 3'd4
  } dma_st_e;

  // beat size in bytes from the peripheral width field
  function automatic logic [2:0] beat_size(input logic [1:0] pw);
    case (pw)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bytes actually taken by one beat: the beat size clipped to what remains
  function automatic logic [2:0] beat_take(input logic [BCNT_W-1:0] left,
                                           input logic [2:0] w);
    return (left < BCNT_W'(w)) ? left[2:0] : w;
  endfunction

  // count qualifies a start for the given trigger mode
  function automatic logic count_ok(input logic [1:0] mode,
                                    input logic [2:0] w,
                                    input logic [BCNT_W-1:0] c);
    return (mode == 2'b00) ? (c != '0) : (c >= BCNT_W'(w));
  endfunction

  function automatic logic trig_hit(input logic [1:0] mode,
                                    input logic sw, input logic rq);
    case (mode)
      2'b00:        return sw;
      2'b01, 2'b10: return rq;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/m2m_dma_bcnt.sv
module m2m_dma_bcnt
  import m2m_dma_pkg::*;
#(
  parameter int NBUF = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [$clog2(NBUF)-1:0]     ld_sel,
  input  logic [BCNT_W-1:0]           ld_val,
  input  logic                        dec_en,
  input  logic [$clog2(NBUF)-1:0]     dec_sel,
  input  logic [2:0]                  dec_amt,
  output logic [NBUF-1:0][BCNT_W-1:0] cnt_q
);
  localparam int SEL_W = $clog2(NBUF);

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[b] <= '0;
      else if (ld_en && ld_sel == SEL_W'(b))
        cnt_q[b] <= ld_val;
      else if (dec_en && dec_sel == SEL_W'(b))
        cnt_q[b] <= cnt_q[b] - BCNT_W'(dec_amt);
    end
  end
endmodule

// File: rtl/m2m_dma_bay.sv
module m2m_dma_bay #(
  parameter int BAY_BYTES = 16,
  localparam int LVL_W = $clog2(BAY_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic             drain,
  input  logic [2:0]       amt,
  output logic [LVL_W-1:0] level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level_q <= '0;
    else if (fill)  level_q <= level_q + LVL_W'(amt);
    else if (drain) level_q <= level_q - LVL_W'(amt);
  end
endmodule

// File: rtl/m2m_dma_fsm.sv
module m2m_dma_fsm
  import m2m_dma_pkg::*;
#(
  parameter int BAY_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic [1:0]        xfer_mode,
  input  logic [1:0]        per_width,
  input  logic              dreq,
  input  logic              bwc_wait,
  input  logic              nfb_irq_en,
  input  logic              bcnt_ld,
  input  logic              bcnt_ld_sel,
  input  logic [BCNT_W-1:0] bcnt_ld_val,
  output logic              rd_req,
  input  logic              rd_ack,
  output logic              wr_req,
  input  logic              wr_ack,
  output logic [2:0]        xfer_bytes,
  output logic              nfb_irq,
  output logic              done,
  output logic [2:0]        state,
  output logic              cur_buf
);
  localparam int LVL_W = $clog2(BAY_BYTES + 1);

  dma_st_e st_q, st_d;
  logic cur_q, cur_d, bwc_empty_q, bwc_empty_d;
  logic irq_q, irq_d, done_q, done_d;

  logic [1:0][BCNT_W-1:0] cnt_q;
  logic [BCNT_W-1:0] cnt_cur, cnt_oth;
  logic [LVL_W-1:0]  bay_lvl;
  logic [2:0]        bsz, rd_amt, wr_amt;
  logic              rd_fire, wr_fire, bay_empty, trig, rd_stop;

  assign cnt_cur   = cnt_q[cur_q];
  assign cnt_oth   = cnt_q[~cur_q];
  assign bsz       = beat_size(per_width);
  assign bay_empty = (bay_lvl == '0);
  assign trig      = trig_hit(xfer_mode, sw_start, dreq);

  assign rd_req  = (st_q == ST_RD);
  assign wr_req  = (st_q == ST_WR) && !bay_empty;
  assign rd_fire = rd_req && rd_ack;
  assign wr_fire = wr_req && wr_ack;
  assign rd_amt  = beat_take(cnt_cur, bsz);
  assign wr_amt  = beat_take(BCNT_W'(bay_lvl), bsz);

  // reading stops when this beat empties the count or no further full beat fits
  assign rd_stop = (cnt_cur == BCNT_W'(rd_amt)) ||
                   (int'(bay_lvl) + int'(rd_amt) + int'(bsz) > BAY_BYTES);

  m2m_dma_bcnt #(.NBUF(2)) u_bcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (bcnt_ld),
    .ld_sel (bcnt_ld_sel),
    .ld_val (bcnt_ld_val),
    .dec_en (rd_fire),
    .dec_sel(cur_q),
    .dec_amt(rd_amt),
    .cnt_q  (cnt_q)
  );

  m2m_dma_bay #(.BAY_BYTES(BAY_BYTES)) u_bay (
    .clk    (clk),
    .rst_n  (rst_n),
    .fill   (rd_fire),
    .drain  (wr_fire),
    .amt    (rd_fire ? rd_amt : wr_amt),
    .level_q(bay_lvl)
  );

  always_comb begin
    st_d        = st_q;
    cur_d       = cur_q;
    bwc_empty_d = bwc_empty_q;
    irq_d       = 1'b0;
    done_d      = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_STALL: begin
        if (trig) begin
          if (count_ok(xfer_mode, bsz, cnt_cur)) begin
            st_d = ST_RD;
          end else if (count_ok(xfer_mode, bsz, cnt_oth)) begin
            st_d  = ST_RD;
            cur_d = ~cur_q;
          end else begin
            st_d = ST_STALL;
          end
        end
      end
      ST_RD: begin
        if (rd_fire) begin
          if (rd_stop) st_d = ST_WR;
        end else if (bwc_wait) begin
          st_d        = ST_BWC;
          bwc_empty_d = bay_empty;
        end
      end
      ST_WR: begin
        if (!bay_empty) begin
          if (!wr_fire && bwc_wait) begin
            st_d        = ST_BWC;
            bwc_empty_d = 1'b0;
          end
        end else if (cnt_cur != '0) begin
          if (xfer_mode == 2'b00 || dreq) st_d = ST_RD;
        end else if (cnt_oth != '0) begin
          st_d  = ST_RD;
          cur_d = ~cur_q;
          irq_d = nfb_irq_en;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_BWC: begin
        if (!bwc_wait) st_d = bwc_empty_q ? ST_RD : ST_WR;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_q       <= 1'b0;
      bwc_empty_q <= 1'b0;
      irq_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      cur_q       <= cur_d;
      bwc_empty_q <= bwc_empty_d;
      irq_q       <= irq_d;
      done_q      <= done_d;
    end
  end

  assign xfer_bytes = rd_fire ? rd_amt : (wr_fire ? wr_amt : 3'd0);
  assign nfb_irq    = irq_q;
  assign done       = done_q;
  assign state      = st_q;
  assign cur_buf    = cur_q;
endmodule

// File: rtl/m2m_dma_chk.sv
module m2m_dma_chk
  import m2m_dma_pkg::*;
#(
  parameter int BAY_BYTES = 16,
  localparam int LVL_W = $clog2(BAY_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        state,
  input logic              rd_req,
  input logic              wr_req,
  input logic [LVL_W-1:0]  bay_lvl,
  input logic [BCNT_W-1:0] cnt_cur,
  input logic [1:0]        xfer_mode,
  input logic              dreq,
  input logic              bwc_wait,
  input logic              bwc_empty,
  input logic              nfb_irq,
  input logic              done
);
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)); // R5

  AST_BAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bay_lvl) <= BAY_BYTES); // R5

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |-> (!rd_req && !wr_req)); // R2

  AST_DREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && bay_lvl == '0 && cnt_cur != '0 && xfer_mode != 2'b00 && !dreq)
      |=> (state == 3'd3)); // R6

  AST_IRQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    nfb_irq |-> (state == 3'd2)); // R7

  AST_BWC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !bwc_wait) |=> (state == (bwc_empty ? 3'd2 : 3'd3))); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == 3'd0 && bay_lvl == '0)); // R9
endmodule

bind m2m_dma_fsm m2m_dma_chk #(.BAY_BYTES(BAY_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state),
  .rd_req   (rd_req),
  .wr_req   (wr_req),
  .bay_lvl  (bay_lvl),
  .cnt_cur  (cnt_cur),
  .xfer_mode(xfer_mode),
  .dreq     (dreq),
  .bwc_wait (bwc_wait),
  .bwc_empty(bwc_empty_q),
  .nfb_irq  (nfb_irq),
  .done     (done)
);

// File: tb/test_m2m_dma_fsm.sv
`timescale 1ns/1ps
module test_m2m_dma_fsm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_start = 0, dreq = 0, bwc_wait = 0, nfb_irq_en = 0;
  logic [1:0] xfer_mode = 0, per_width = 0;
  logic bcnt_ld = 0, bcnt_ld_sel = 0;
  logic [15:0] bcnt_ld_val = 0;
  logic rd_ack_en = 1, wr_ack_en = 1;
  logic rd_req, rd_ack, wr_req, wr_ack, nfb_irq, done, cur_buf;
  logic [2:0] xfer_bytes, state;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign rd_ack = rd_req && rd_ack_en;
  assign wr_ack = wr_req && wr_ack_en;

  m2m_dma_fsm i_m2m_dma_fsm (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .xfer_mode(xfer_mode),
    .per_width(per_width), .dreq(dreq), .bwc_wait(bwc_wait),
    .nfb_irq_en(nfb_irq_en), .bcnt_ld(bcnt_ld), .bcnt_ld_sel(bcnt_ld_sel),
    .bcnt_ld_val(bcnt_ld_val), .rd_req(rd_req), .rd_ack(rd_ack),
    .wr_req(wr_req), .wr_ack(wr_ack), .xfer_bytes(xfer_bytes),
    .nfb_irq(nfb_irq), .done(done), .state(state), .cur_buf(cur_buf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // scoreboard driver side: expected beat/pulse sequence from the requirements
  task automatic push_expected(input int first, input int second, input int w, input bit irq_en);
    int c[2];
    c[0] = first; c[1] = second;
    for (int k = 0; k < 2; k++) begin
      int left = c[k];
      if (left == 0) continue;
      if (k == 1 && irq_en) exp_q.push_back({8'h49, 8'd0});
      while (left > 0) begin
        int bay = 0;
        do begin
          int m = (left < w) ? left : w;
          exp_q.push_back({8'h52, 8'(m)});
          bay += m; left -= m;
        end while (left > 0 && bay + w <= 16);
        while (bay > 0) begin
          int m = (bay < w) ? bay : w;
          exp_q.push_back({8'h57, 8'(m)});
          bay -= m;
        end
      end
    end
    exp_q.push_back({8'h44, 8'd0});
  endtask

  // scoreboard monitor side
  task automatic pop_cmp(input logic [7:0] kind, input int val, input string req);
    logic [15:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, req, int'(kind), 0);
    end else begin
      e = exp_q.pop_front();
      chk(e == {kind, 8'(val)}, req, int'({kind, 8'(val)}), int'(e));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (nfb_irq) pop_cmp(8'h49, 0, "R7");
      if (rd_req && rd_ack) pop_cmp(8'h52, int'(xfer_bytes), "R5");
      if (wr_req && wr_ack) pop_cmp(8'h57, int'(xfer_bytes), "R6");
      if (done) pop_cmp(8'h44, 0, "R9");
    end
  end

  task automatic load(input logic sel, input int val);
    bcnt_ld = 1; bcnt_ld_sel = sel; bcnt_ld_val = 16'(val);
    step();
    bcnt_ld = 0;
  endtask

  task automatic pulse_trig(input logic use_dreq);
    if (use_dreq) dreq = 1; else sw_start = 1;
    step();
    dreq = 0; sw_start = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    do begin step(); n++; end while (!done && n < 2000);
    chk(done == 1'b1, req, int'(done), 1);
    step();
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(state == 3'd0, req, int'(state), 0);
  endtask

  task automatic run_xfer(input logic [1:0] mode, input logic [1:0] pw, input int first,
                          input int second, input bit irq_en, input string req);
    int w;
    w = (pw == 2'b00) ? 1 : (pw == 2'b01) ? 2 : 4;
    xfer_mode = mode; per_width = pw; nfb_irq_en = irq_en;
    load(cur_buf, first);
    load(~cur_buf, second);
    push_expected(first, second, w, irq_en);
    pulse_trig(mode != 2'b00);
    wait_done(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R10 reset state
    chk(state == 3'd0, "R10", int'(state), 0);
    chk(cur_buf == 1'b0, "R10", int'(cur_buf), 0);
    chk(!rd_req && !wr_req, "R10", int'({rd_req, wr_req}), 0);
    chk(!done && !nfb_irq, "R10", int'({done, nfb_irq}), 0);

    // R2 / R3: zero counts in software mode stall
    xfer_mode = 2'b00; per_width = 2'b10;
    pulse_trig(1'b0);
    chk(state == 3'd1, "R2", int'(state), 1);
    chk(!rd_req && !wr_req, "R3", int'({rd_req, wr_req}), 0);

    // R4: count 3 is below a word beat in request mode, still stalled
    xfer_mode = 2'b01;
    load(1'b0, 3);
    pulse_trig(1'b1);
    chk(state == 3'd1, "R4", int'(state), 1);
    // R4 boundary: count 4 with word width is valid
    run_xfer(2'b01, 2'b10, 4, 0, 1'b0, "R4");

    // R1: non-selected triggers ignored
    load(1'b0, 8);
    xfer_mode = 2'b11;
    sw_start = 1; dreq = 1; step(); sw_start = 0; dreq = 0;
    chk(state == 3'd0, "R1", int'(state), 0);
    xfer_mode = 2'b01;
    pulse_trig(1'b0);
    chk(state == 3'd0, "R1", int'(state), 0);
    xfer_mode = 2'b00;
    pulse_trig(1'b1);
    chk(state == 3'd0, "R1", int'(state), 0);

    // R5: software mode, word beats, 40 bytes in three fills
    run_xfer(2'b00, 2'b10, 40, 0, 1'b0, "R5");
    // R5: byte beats with partial tail, word width and odd count
    run_xfer(2'b00, 2'b00, 19, 0, 1'b0, "R5");
    run_xfer(2'b00, 2'b10, 7, 0, 1'b0, "R5");

    // R7: buffer change with and without interrupt
    run_xfer(2'b00, 2'b00, 3, 5, 1'b1, "R7");
    chk(cur_buf == 1'b1, "R7", int'(cur_buf), 1);
    run_xfer(2'b00, 2'b01, 6, 20, 1'b0, "R7");
    chk(cur_buf == 1'b0, "R7", int'(cur_buf), 0);

    // R6: request mode waits for dreq before a second fill
    xfer_mode = 2'b01; per_width = 2'b01; nfb_irq_en = 0;
    load(cur_buf, 20);
    load(~cur_buf, 0);
    push_expected(20, 0, 2, 1'b0);
    pulse_trig(1'b1);
    begin
      int n = 0;
      do begin step(); n++; end while (!(state == 3'd3 && !wr_req) && n < 200);
    end
    repeat (5) step();
    chk(state == 3'd3, "R6", int'(state), 3);
    chk(!rd_req && !wr_req, "R6", int'({rd_req, wr_req}), 0);
    pulse_trig(1'b1);
    wait_done("R6");

    // R8: wait state entered from read with empty bay, then from write with data
    xfer_mode = 2'b00; per_width = 2'b10;
    load(cur_buf, 8);
    load(~cur_buf, 0);
    push_expected(8, 0, 4, 1'b0);
    rd_ack_en = 0; wr_ack_en = 0;
    pulse_trig(1'b0);
    chk(state == 3'd2, "R8", int'(state), 2);
    bwc_wait = 1; step();
    chk(state == 3'd4, "R8", int'(state), 4);
    bwc_wait = 0; step();
    chk(state == 3'd2, "R8", int'(state), 2);
    rd_ack_en = 1;
    begin
      int n = 0;
      do begin step(); n++; end while (state != 3'd3 && n < 200);
    end
    bwc_wait = 1; step();
    chk(state == 3'd4, "R8", int'(state), 4);
    bwc_wait = 0; step();
    chk(state == 3'd3, "R8", int'(state), 3);
    wr_ack_en = 1;
    wait_done("R8");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule